// File: doc/BRIEF.md
# Background Memory Signature Checker

The block keeps watch over a small code memory while the rest of the engine runs. Once software sets its enable bit, it reads the memory from the lowest address to the highest, one word per clock, and folds every word into a CRC-32 signature. It starts a new pass straight after the last address, and never stops of its own accord unless a fault is found. At the end of each pass it compares the signature with an expected value that software has loaded. On a difference it raises a mismatch flag and drops its own enable bit, so a damaged memory is reported once and not scanned again until software acts.

The same register set gathers the global exception state. The engine's microcode and its illegal-instruction detector are each modelled as a single-cycle input pulse that sets a sticky bit. A single write-one strobe clears those two bits and the mismatch flag together. An exception request output is high while any of the three is set. A read-only field reports how many 2 KB blocks the memory holds. The memory itself is a synchronous-read array with its own write port, which is used to load it.

Top module: `memsig_top`

## Requirements
- R1: Bits 12:8 of the control register (address 0) read NUM_BLOCKS-1; writes do not change them, so three blocks read as 5'b00010.
- R2: After hard reset the control register reads only the size field, the expected-value register (address 1) reads 0 and exc_req is 0.
- R3: While enable (control bit 0) is 1, the block reads addresses 0 to DEPTH-1 in ascending order, again and again. Each pass starts from seed 0xFFFFFFFF and folds each 32-bit word in MSB first with polynomial 0x04C11DB7, with no final inversion. When the result equals the expected value, the flag stays 0 and enable stays 1 over any number of passes.
- R4: When a pass result differs from the expected value, the mismatch flag (control bit 1) is set and enable is cleared on the edge DEPTH+1 clocks after the edge that wrote enable to 1.
- R5: A write that takes enable from 0 to 1 clears the mismatch flag on the same edge.
- R6: While enable is 0 the scan returns to address 0 and the seed, so a pass that starts after an abort is timed and computed as a fresh one.
- R7: A ucode_evt pulse sets control bit 2 and an illeg_evt pulse sets control bit 3. Both stay set until cleared.
- R8: Writing the control register with bit 7 set clears bits 1, 2 and 3. With bit 7 at 0 they are kept.
- R9: exc_req is 1 exactly when any of control bits 1, 2 or 3 is set.
- R10: A soft_rst pulse clears control bits 2 and 3 and leaves the enable bit and the mismatch flag unchanged.
- R11: An event pulse in the same cycle as a clearing write leaves its bit set.
- R12: Read data appears on the clock after the read strobe. Bit 7, all other undefined control bits and addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| soft_rst | input | 1 | Engine soft reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| mem_we | input | 1 | Memory load strobe |
| mem_waddr | input | ADDR_W | Memory load address |
| mem_wdata | input | 32 | Memory load data |
| ucode_evt | input | 1 | Microcode exception pulse |
| illeg_evt | input | 1 | Illegal instruction pulse |
| exc_req | output | 1 | Global exception request |

## Verification
The hardest case to reach from the ports is the end-of-pass compare that follows an aborted pass. The bench has to show that a pass which starts after enable was dropped mid-sweep holds no leftover address or partial signature. To reach it, the bench enables the scan with a deliberately wrong expected value, drops enable halfway through the memory and raises it again one cycle later. It then checks that the flag rises on exactly the edge a fresh pass predicts. The same detour with the correct value must produce no flag at all. Across several memory fills the bench also flips a single bit of the expected value, so that every compare is exercised against a signature the bench computes bit by bit.

// File: rtl/memsig_pkg.sv
`timescale 1ns/1ps
package memsig_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
  localparam int SIZE_W   = 5;
  localparam int CB_EN    = 0;
  localparam int CB_MISS  = 1;
  localparam int CB_UCODE = 2;
  localparam int CB_ILLEG = 3;
  localparam int CB_GCLR  = 7;
  localparam int CB_SIZE  = 8;
  localparam logic [1:0] RA_CTRL   = 2'd0;
  localparam logic [1:0] RA_EXPECT = 2'd1;

  // one 32-bit word folded into the running signature, MSB first
  function automatic logic [31:0] crc32_fold(input logic [31:0] crc, input logic [31:0] word);
    logic [31:0] r;
    r = crc ^ word;
    for (int i = 0; i < 32; i++) begin
      r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic en, input logic miss, input logic ucode,
                                            input logic illeg, input logic [SIZE_W-1:0] sz);
    logic [31:0] v;
    v = '0;
    v[CB_EN]    = en;
    v[CB_MISS]  = miss;
    v[CB_UCODE] = ucode;
    v[CB_ILLEG] = illeg;
    v[CB_SIZE +: SIZE_W] = sz;
    return v;
  endfunction
endpackage

// File: rtl/memsig_mem.sv
`timescale 1ns/1ps
module memsig_mem #(
  parameter int WORDS  = 1536,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [31:0]       wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WORDS);

  logic [31:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < LIMIT)) store[waddr] <= wdata;
    if ({1'b0, raddr} < LIMIT) rdata <= store[raddr];
    else                       rdata <= '0;
  end
endmodule

// File: rtl/memsig_scan.sv
`timescale 1ns/1ps
module memsig_scan
  import memsig_pkg::*;
#(
  parameter int DEPTH  = 1536,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [31:0]       expected,
  input  logic [31:0]       rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       crc_state,
  output logic              pass_done,
  output logic              sig_miss
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;
  logic              valid_q, last_q;
  logic [31:0]       crc_q, crc_next;

  assign crc_next  = crc32_fold(crc_q, rd_word);
  assign pass_done = en && valid_q && last_q;
  assign sig_miss  = pass_done && (crc_next != expected);
  assign rd_addr   = addr_q;
  assign crc_state = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      crc_q   <= CRC_SEED;
    end else if (!en) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      crc_q   <= CRC_SEED;
    end else begin
      addr_q  <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
      valid_q <= 1'b1;
      last_q  <= (addr_q == LAST);
      if (valid_q) crc_q <= last_q ? CRC_SEED : crc_next;
    end
  end
endmodule

// File: rtl/memsig_regs.sv
`timescale 1ns/1ps
module memsig_regs
  import memsig_pkg::*;
#(
  parameter logic [SIZE_W-1:0] SIZE_VAL = 5'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ucode_evt,
  input  logic        illeg_evt,
  input  logic        sig_miss,
  output logic        en_q,
  output logic        miss_q,
  output logic        ucode_q,
  output logic        illeg_q,
  output logic [31:0] expect_q,
  output logic        en_rise,
  output logic        gclr_hit,
  output logic        exc_req
);
  logic wr_ctrl, wr_expect;

  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_expect = reg_wr && (reg_addr == RA_EXPECT);
  assign gclr_hit  = wr_ctrl && reg_wdata[CB_GCLR];
  assign en_rise   = wr_ctrl && reg_wdata[CB_EN] && !en_q;
  assign exc_req   = miss_q | ucode_q | illeg_q;

  // hard reset only: enable, flag, expected value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      miss_q   <= 1'b0;
      expect_q <= '0;
    end else begin
      if (sig_miss)     en_q <= 1'b0;
      else if (wr_ctrl) en_q <= reg_wdata[CB_EN];

      if (sig_miss)                 miss_q <= 1'b1;
      else if (en_rise || gclr_hit) miss_q <= 1'b0;

      if (wr_expect) expect_q <= reg_wdata;
    end
  end

  // engine exception bits: set wins over any clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucode_q <= 1'b0;
      illeg_q <= 1'b0;
    end else begin
      if (ucode_evt)                  ucode_q <= 1'b1;
      else if (gclr_hit || soft_rst)  ucode_q <= 1'b0;
      if (illeg_evt)                  illeg_q <= 1'b1;
      else if (gclr_hit || soft_rst)  illeg_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:   reg_rdata <= pack_ctrl(en_q, miss_q, ucode_q, illeg_q, SIZE_VAL);
        RA_EXPECT: reg_rdata <= expect_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/memsig_top.sv
`timescale 1ns/1ps
module memsig_top
  import memsig_pkg::*;
#(
  parameter int BLOCK_WORDS = 512,
  parameter int NUM_BLOCKS  = 3,
  localparam int DEPTH      = BLOCK_WORDS * NUM_BLOCKS,
  localparam int ADDR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [31:0]       mem_wdata,
  input  logic              ucode_evt,
  input  logic              illeg_evt,
  output logic              exc_req
);
  localparam logic [SIZE_W-1:0] SIZE_VAL = SIZE_W'(NUM_BLOCKS - 1);

  // named internal events, observed by the bound checker
  logic              en_w, miss_w, ucode_w, illeg_w;
  logic              en_rise_w, gclr_w, sig_miss_w, pass_done_w;
  logic [31:0]       expect_w, rd_word_w, crc_w;
  logic [ADDR_W-1:0] scan_addr_w;

  memsig_regs #(.SIZE_VAL(SIZE_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ucode_evt(ucode_evt), .illeg_evt(illeg_evt), .sig_miss(sig_miss_w),
    .en_q(en_w), .miss_q(miss_w), .ucode_q(ucode_w), .illeg_q(illeg_w),
    .expect_q(expect_w), .en_rise(en_rise_w), .gclr_hit(gclr_w),
    .exc_req(exc_req)
  );

  memsig_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .en(en_w), .expected(expect_w),
    .rd_word(rd_word_w), .rd_addr(scan_addr_w), .crc_state(crc_w),
    .pass_done(pass_done_w), .sig_miss(sig_miss_w)
  );

  memsig_mem #(.WORDS(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(scan_addr_w), .rdata(rd_word_w)
  );
endmodule

// File: rtl/memsig_chk.sv
`timescale 1ns/1ps
module memsig_chk
  import memsig_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [SIZE_W-1:0] SIZE_VAL = 5'd2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              ucode_evt,
  input logic              illeg_evt,
  input logic              exc_req,
  input logic              en_q,
  input logic              miss_q,
  input logic              ucode_q,
  input logic              illeg_q,
  input logic              sig_miss,
  input logic              pass_done,
  input logic              en_rise,
  input logic              gclr_hit,
  input logic [ADDR_W-1:0] scan_addr,
  input logic [31:0]       crc_q
);
  assert_size_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == RA_CTRL) |=> (reg_rdata[CB_SIZE +: SIZE_W] == SIZE_VAL && !reg_rdata[CB_GCLR]));

  assert_match_keeps_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_done && !sig_miss && !reg_wr) |=> (en_q && !miss_q));

  assert_auto_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sig_miss |=> (!en_q && miss_q));

  assert_enable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (en_q && !miss_q));

  assert_idle_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (scan_addr == '0 && crc_q == CRC_SEED));

  assert_ucode_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_evt |=> ucode_q);

  assert_illeg_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illeg_evt |=> illeg_q);

  assert_gclr_quiets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gclr_hit && !ucode_evt && !illeg_evt && !sig_miss) |=> !exc_req);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !reg_wr && !sig_miss && !ucode_evt && !illeg_evt)
      |=> (en_q == $past(en_q) && miss_q == $past(miss_q) && !ucode_q && !illeg_q));

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gclr_hit && ucode_evt) |=> ucode_q);

  assert_unused_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[1]) |=> (reg_rdata == '0));
endmodule

bind memsig_top memsig_chk #(.ADDR_W(ADDR_W), .SIZE_VAL(SIZE_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .ucode_evt(ucode_evt), .illeg_evt(illeg_evt),
  .exc_req(exc_req), .en_q(en_w), .miss_q(miss_w), .ucode_q(ucode_w), .illeg_q(illeg_w),
  .sig_miss(sig_miss_w), .pass_done(pass_done_w), .en_rise(en_rise_w), .gclr_hit(gclr_w),
  .scan_addr(scan_addr_w), .crc_q(crc_w)
);

// File: tb/sim_memsig_top.sv
`timescale 1ns/1ps
module sim_memsig_top;
  localparam int BW = 4;
  localparam int NB = 3;
  localparam int DEPTH = BW * NB;
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] BASE = 32'h0000_0200; // size field = NB-1 at bits 12:8

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, reg_wr = 0, reg_rd = 0, mem_we = 0, ucode_evt = 0, illeg_evt = 0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, mem_wdata = '0;
  logic [AW-1:0] mem_waddr = '0;
  logic [31:0] reg_rdata;
  logic exc_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] img [DEPTH];

  always #2.5 clk = ~clk;

  memsig_top #(.BLOCK_WORDS(BW), .NUM_BLOCKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ucode_evt(ucode_evt), .illeg_evt(illeg_evt), .exc_req(exc_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ucode_evt = 1; else if (which == 1) illeg_evt = 1; else soft_rst = 1;
    @(negedge clk); ucode_evt = 0; illeg_evt = 0; soft_rst = 0;
  endtask

  // bit-serial restatement of the signature rule
  function automatic logic [31:0] ref_sig();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < DEPTH; w++) begin
      for (int b = 31; b >= 0; b--) begin
        logic fb;
        fb = c[31] ^ img[w][b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c;
  endfunction

  task automatic fill(input int p);
    for (int i = 0; i < DEPTH; i++) begin
      img[i] = (32'(i) * 32'h9E37_79B1) ^ (32'(p + 1) * 32'h7F4A_7C15) ^ {8'(p), 8'(i), 16'hA5C3};
      @(negedge clk); mem_we = 1; mem_waddr = AW'(i); mem_wdata = img[i];
    end
    @(negedge clk); mem_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, sig;
    tick(3);
    rst_n = 1;
    tick(1);
    check("R2 exc_req after reset", {31'd0, exc_req}, 32'd0);
    rd_reg(2'd0, d); check("R2 R1 ctrl after reset", d, BASE);
    rd_reg(2'd1, d); check("R2 expected after reset", d, 32'd0);
    rd_reg(2'd2, d); check("R12 addr 2 reads zero", d, 32'd0);
    rd_reg(2'd3, d); check("R12 addr 3 reads zero", d, 32'd0);
    wr_reg(2'd0, 32'hFFFF_FF7E);
    rd_reg(2'd0, d); check("R1 R12 size and unused bits ignore writes", d, BASE);

    for (int p = 0; p < 6; p++) begin
      fill(p);
      sig = ref_sig();
      wr_reg(2'd1, sig);
      rd_reg(2'd1, d); check("R12 expected readback", d, sig);
      wr_reg(2'd0, 32'd1);
      tick(3 * DEPTH + 4);
      check("R3 no flag on matching passes", {31'd0, exc_req}, 32'd0);
      rd_reg(2'd0, d); check("R3 still enabled", d, BASE | 32'h1);
      wr_reg(2'd0, 32'd0);
      wr_reg(2'd1, sig ^ (32'h1 << (p * 5)));
      wr_reg(2'd0, 32'd1);
      tick(DEPTH);
      check("R4 flag not before pass end", {31'd0, exc_req}, 32'd0);
      tick(1);
      check("R4 R9 flag at pass end", {31'd0, exc_req}, 32'd1);
      rd_reg(2'd0, d); check("R4 flag set enable dropped", d, BASE | 32'h2);
      wr_reg(2'd1, sig);
      wr_reg(2'd0, 32'd1);
      check("R5 enable clears flag", {31'd0, exc_req}, 32'd0);
      rd_reg(2'd0, d); check("R5 ctrl after re-enable", d, BASE | 32'h1);
      wr_reg(2'd0, 32'd0);
    end

    // R6: abort mid-pass, restart one cycle later
    wr_reg(2'd1, sig ^ 32'h8000_0000);
    wr_reg(2'd0, 32'd1);
    tick(DEPTH / 2);
    wr_reg(2'd0, 32'd0);
    wr_reg(2'd0, 32'd1);
    tick(DEPTH);
    check("R6 restarted pass not early", {31'd0, exc_req}, 32'd0);
    tick(1);
    check("R6 restarted pass timed fresh", {31'd0, exc_req}, 32'd1);
    wr_reg(2'd1, sig);
    wr_reg(2'd0, 32'd1);
    tick(DEPTH / 2 + 1);
    wr_reg(2'd0, 32'd0);
    tick(2);
    wr_reg(2'd0, 32'd1);
    tick(3 * DEPTH);
    check("R6 restarted signature reseeded", {31'd0, exc_req}, 32'd0);
    rd_reg(2'd0, d); check("R6 running after restart", d, BASE | 32'h1);
    wr_reg(2'd0, 32'd0);

    // R7 R8 R9 R10: exception bits
    pulse(0);
    check("R9 req from microcode bit", {31'd0, exc_req}, 32'd1);
    tick(5);
    rd_reg(2'd0, d); check("R7 microcode bit sticky", d, BASE | 32'h4);
    wr_reg(2'd0, 32'd0);
    rd_reg(2'd0, d); check("R8 write without clear keeps bits", d, BASE | 32'h4);
    wr_reg(2'd0, 32'h80);
    rd_reg(2'd0, d); check("R8 R12 clear write, bit 7 reads 0", d, BASE);
    check("R8 req dropped", {31'd0, exc_req}, 32'd0);
    pulse(1);
    rd_reg(2'd0, d); check("R7 illegal bit set", d, BASE | 32'h8);
    check("R9 req from illegal bit", {31'd0, exc_req}, 32'd1);
    pulse(2);
    rd_reg(2'd0, d); check("R10 soft reset clears illegal", d, BASE);

    wr_reg(2'd0, 32'd1);
    pulse(0);
    pulse(2);
    rd_reg(2'd0, d); check("R10 soft reset keeps enable", d, BASE | 32'h1);
    wr_reg(2'd0, 32'd0);
    wr_reg(2'd1, ~sig);
    wr_reg(2'd0, 32'd1);
    tick(DEPTH + 2);
    pulse(2);
    rd_reg(2'd0, d); check("R10 soft reset keeps flag", d, BASE | 32'h2);
    check("R9 req from flag alone", {31'd0, exc_req}, 32'd1);
    wr_reg(2'd0, 32'h80);
    rd_reg(2'd0, d); check("R8 clear write drops flag", d, BASE);

    // R11: event and clear in the same cycle
    @(negedge clk); ucode_evt = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h80;
    @(negedge clk); ucode_evt = 0; reg_wr = 0;
    rd_reg(2'd0, d); check("R11 event beats clear", d, BASE | 32'h4);
    wr_reg(2'd0, 32'h80);
    rd_reg(2'd0, d); check("R8 later clear works", d, BASE);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule